// File: doc/BRIEF.md
# DDR SDRAM Command Rule Monitor

This block is a passive observer on the command bus of a four-bank double-data-rate SDRAM. On each clock it samples the clock-enable, the decoded command, the bank select and the row/column address. It keeps its own copy of the state the memory should be in. That state covers which banks hold an open row and which row each one holds. It also covers the burst length, burst type, CAS latency and operating-mode bits last written to the main mode register, whether a read or write burst is still moving, and how long ago the DLL was last reset.

Any command that breaks the access rules sets a sticky error flag. A three-bit code records the first such violation, and it holds until reset. The monitor never drives the bus. It sits beside a memory controller in simulation or in silicon debug logic and reports the first protocol slip the controller makes. The block has no data stream and no handshake. All of its pins are plain control and status signals.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: A command is observed only on a clock edge where `cke` is high; with `cke` low the command inputs have no effect on bank state, mode fields or the error outputs. Command codes on `cmd`: 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 PRECHARGE ALL, 6 AUTO REFRESH, 7 LOAD MODE.
- R2: ACTIVE to an idle bank marks it open and stores the 13-bit `addr` as its row, visible in `bank_row` bits [13*b+12:13*b] for bank b. ACTIVE to a bank that is already open raises error code 1 and leaves that bank's row unchanged.
- R3: A READ or WRITE whose bank is idle raises error code 2.
- R4: PRECHARGE closes the bank selected by `ba`; PRECHARGE ALL closes every bank.
- R5: A LOAD MODE with `ba`=0 that raises no error latches `addr[2:0]` into `burst_len`, `addr[3]` into `burst_type`, `addr[6:4]` into `cas_lat` and `addr[12:7]` into `op_mode`. A LOAD MODE with `ba`=1 (extended register) changes none of these. Reset values are burst_len 1, burst_type 0, cas_lat 2, op_mode 0.
- R6: A main LOAD MODE whose `addr[2:0]` is not 1, 2 or 3 (burst of 2, 4, 8) raises error code 4, and the load is discarded.
- R7: The DLL-reset bit (`addr[8]`, `op_mode[1]`) is never retained: `op_mode[1]` always reads 0.
- R8: A LOAD MODE issued while any bank is open, or while a burst is in progress, raises error code 3 and is discarded. A burst occupies the 1, 2 or 4 edges (burst length / 2) that follow an accepted READ or WRITE.
- R9: After an accepted main LOAD MODE with `addr[8]` set, a READ issued fewer than 200 clock edges later raises error code 5. A READ exactly 200 edges later is legal. Error code 2 takes precedence over code 5.
- R10: `err_flag` stays high until reset once set. `err_code` holds the first violation's code, and it is 0 while no error has occurred. Later violations do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable of the memory; commands count only when high |
| cmd | input | 3 | Decoded command code |
| ba | input | 2 | Bank select |
| addr | input | 13 | Row address, column address or mode value |
| bank_open | output | 4 | One bit per bank, high while a row is open |
| bank_row | output | 52 | Open row of each bank, 13 bits per bank |
| burst_len | output | 3 | Latched burst-length code |
| burst_type | output | 1 | Latched burst type (0 sequential, 1 interleaved) |
| cas_lat | output | 3 | Latched CAS latency code |
| op_mode | output | 6 | Latched operating-mode bits, DLL-reset position forced to 0 |
| err_flag | output | 1 | Sticky violation flag |
| err_code | output | 3 | Code of the first violation |

## Verification
Some properties are checked on every cycle. These are: the error flag and code never change once set, a freshly set flag always carries a non-zero code, and a READ or WRITE to an idle bank always produces code 2. Also checked each cycle are that an ACTIVE opens its bank, that PRECHARGE ALL clears every bank, that commands with `cke` low change nothing, and that the stored burst length and DLL-reset bit stay within their rules. Other behaviours depend on history that only the bench's scenarios build up. These include the 199-versus-200 edge boundary after a DLL reset and the mode load that lands while a long burst is still draining. They also include discarded mode loads leaving the old fields in place, and the first violation winning over later ones. A reference model checks all of them alongside long random command streams.

// File: rtl/ddr_mon_pkg.sv
package ddr_mon_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_PALL = 3'd5,
    CMD_REF  = 3'd6,
    CMD_LMR  = 3'd7
  } cmd_e;

  typedef enum logic [2:0] {
    ERR_NONE      = 3'd0,
    ERR_ACT_OPEN  = 3'd1,
    ERR_RW_IDLE   = 3'd2,
    ERR_MODE_BUSY = 3'd3,
    ERR_BAD_BL    = 3'd4,
    ERR_DLL_GAP   = 3'd5
  } err_e;

  typedef struct packed {
    logic [5:0] op;
    logic [2:0] cl;
    logic       bt;
    logic [2:0] bl;
  } mode_t;

  localparam logic [2:0] BL_RESET = 3'd1;
  localparam logic [2:0] CL_RESET = 3'd2;

  // legal burst-length codes: 1 -> 2 beats, 2 -> 4, 3 -> 8
  function automatic logic bl_ok(input logic [2:0] code);
    return (code == 3'd1) || (code == 3'd2) || (code == 3'd3);
  endfunction

  // clock edges a burst occupies (two beats per clock)
  function automatic logic [2:0] bl_cycles(input logic [2:0] code);
    case (code)
      3'd2:    return 3'd2;
      3'd3:    return 3'd4;
      default: return 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/ddr_bank_tracker.sv
module ddr_bank_tracker #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       act_en,
  input  logic                       pre_en,
  input  logic                       pall_en,
  input  logic [BA_W-1:0]            bank_sel,
  input  logic [ROW_W-1:0]           row_in,
  output logic [NUM_BANKS-1:0]       open_q,
  output logic [NUM_BANKS*ROW_W-1:0] rows_q
);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (bank_sel == BA_W'(b));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_q[b]                 <= 1'b0;
        rows_q[b*ROW_W +: ROW_W]  <= '0;
      end else if (act_en && hit) begin
        open_q[b]                 <= 1'b1;
        rows_q[b*ROW_W +: ROW_W]  <= row_in;
      end else if (pall_en || (pre_en && hit)) begin
        open_q[b]                 <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ddr_down_timer.sv
module ddr_down_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         busy
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/ddr_mode_reg.sv
module ddr_mode_reg
  import ddr_mon_pkg::*;
#(
  parameter int DLL_BIT = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [12:0] value,
  output mode_t       mode_q
);

  mode_t nxt;

  always_comb begin
    nxt.bl = value[2:0];
    nxt.bt = value[3];
    nxt.cl = value[6:4];
    nxt.op = value[12:7];
    nxt.op[DLL_BIT-7] = 1'b0;   // self-clearing position is never stored
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q.bl <= BL_RESET;
      mode_q.bt <= 1'b0;
      mode_q.cl <= CL_RESET;
      mode_q.op <= '0;
    end else if (wr_en) begin
      mode_q <= nxt;
    end
  end

endmodule

// File: rtl/ddr_cmd_monitor.sv
module ddr_cmd_monitor
  import ddr_mon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int DLL_GAP   = 200,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cke,
  input  logic [2:0]                 cmd,
  input  logic [BA_W-1:0]            ba,
  input  logic [ROW_W-1:0]           addr,
  output logic [NUM_BANKS-1:0]       bank_open,
  output logic [NUM_BANKS*ROW_W-1:0] bank_row,
  output logic [2:0]                 burst_len,
  output logic                       burst_type,
  output logic [2:0]                 cas_lat,
  output logic [5:0]                 op_mode,
  output logic                       err_flag,
  output logic [2:0]                 err_code
);

  localparam int DLL_W   = $clog2(DLL_GAP + 1);
  localparam int BURST_W = 3;
  localparam int DLL_BIT = 8;

  cmd_e  cmd_v;
  err_e  err_now;
  mode_t mode_q;
  logic  sel_open, any_open, lmr_main;
  logic  burst_busy, dll_busy;
  logic  act_en, pre_en, pall_en, rw_ok, mode_wr, dll_load;

  assign cmd_v    = cke ? cmd_e'(cmd) : CMD_NOP;
  assign sel_open = bank_open[ba];
  assign any_open = |bank_open;
  assign lmr_main = (cmd_v == CMD_LMR) && (ba == '0);

  always_comb begin
    err_now = ERR_NONE;
    case (cmd_v)
      CMD_ACT: if (sel_open) err_now = ERR_ACT_OPEN;
      CMD_RD: begin
        if (!sel_open)     err_now = ERR_RW_IDLE;
        else if (dll_busy) err_now = ERR_DLL_GAP;
      end
      CMD_WR:  if (!sel_open) err_now = ERR_RW_IDLE;
      CMD_LMR: begin
        if (any_open || burst_busy)              err_now = ERR_MODE_BUSY;
        else if (lmr_main && !bl_ok(addr[2:0]))  err_now = ERR_BAD_BL;
      end
      default: err_now = ERR_NONE;
    endcase
  end

  assign act_en   = (cmd_v == CMD_ACT) && !sel_open;
  assign pre_en   = (cmd_v == CMD_PRE);
  assign pall_en  = (cmd_v == CMD_PALL);
  assign rw_ok    = ((cmd_v == CMD_RD) || (cmd_v == CMD_WR)) && sel_open;
  assign mode_wr  = lmr_main && (err_now == ERR_NONE);
  assign dll_load = mode_wr && addr[DLL_BIT];

  ddr_bank_tracker #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_banks (
    .clk      (clk),
    .rst_n    (rst_n),
    .act_en   (act_en),
    .pre_en   (pre_en),
    .pall_en  (pall_en),
    .bank_sel (ba),
    .row_in   (addr),
    .open_q   (bank_open),
    .rows_q   (bank_row)
  );

  ddr_mode_reg #(.DLL_BIT(DLL_BIT)) u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (mode_wr),
    .value  (addr[12:0]),
    .mode_q (mode_q)
  );

  ddr_down_timer #(.W(BURST_W)) u_burst (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (rw_ok),
    .load_val (bl_cycles(mode_q.bl)),
    .busy     (burst_busy)
  );

  ddr_down_timer #(.W(DLL_W)) u_dll (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (dll_load),
    .load_val (DLL_W'(DLL_GAP - 1)),
    .busy     (dll_busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_flag <= 1'b0;
      err_code <= ERR_NONE;
    end else if (!err_flag && (err_now != ERR_NONE)) begin
      err_flag <= 1'b1;
      err_code <= err_now;
    end
  end

  assign burst_len  = mode_q.bl;
  assign burst_type = mode_q.bt;
  assign cas_lat    = mode_q.cl;
  assign op_mode    = mode_q.op;

endmodule

// File: rtl/ddr_cmd_monitor_chk.sv
module ddr_cmd_monitor_chk #(
  parameter int NUM_BANKS = 4,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cke,
  input logic [2:0]           cmd,
  input logic [BA_W-1:0]      ba,
  input logic [NUM_BANKS-1:0] bank_open,
  input logic [2:0]           burst_len,
  input logic [5:0]           op_mode,
  input logic                 err_flag,
  input logic [2:0]           err_code
);

  p_cke_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> ($stable(bank_open) && $stable(err_flag)));

  p_act_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && cmd == 3'd1) |=> bank_open[$past(ba)]);

  p_rw_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && (cmd == 3'd2 || cmd == 3'd3) && !bank_open[ba] && !err_flag)
      |=> (err_flag && err_code == 3'd2));

  p_pall_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && cmd == 3'd5) |=> (bank_open == '0));

  p_bl_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_len == 3'd1 || burst_len == 3'd2 || burst_len == 3'd3));

  p_dll_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !op_mode[1]);

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> (err_flag && $stable(err_code)));

  p_code_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> (err_code != 3'd0));

endmodule

bind ddr_cmd_monitor ddr_cmd_monitor_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cke       (cke),
  .cmd       (cmd),
  .ba        (ba),
  .bank_open (bank_open),
  .burst_len (burst_len),
  .op_mode   (op_mode),
  .err_flag  (err_flag),
  .err_code  (err_code)
);

// File: tb/sim_ddr_cmd_monitor.sv
`timescale 1ns/1ps
module sim_ddr_cmd_monitor;

  localparam int GAP = 200;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cke;
  logic [2:0]  cmd;
  logic [1:0]  ba;
  logic [12:0] addr;
  logic [3:0]  bank_open;
  logic [51:0] bank_row;
  logic [2:0]  burst_len, cas_lat, err_code;
  logic        burst_type, err_flag;
  logic [5:0]  op_mode;

  int n_chk  = 0;
  int n_fail = 0;

  // reference state
  logic        m_open [4];
  logic [12:0] m_row  [4];
  logic [2:0]  m_bl, m_cl, m_code;
  logic        m_bt, m_err;
  logic [5:0]  m_op;
  int          m_burst, m_dll;

  always #4 clk = ~clk;

  ddr_cmd_monitor u0 (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cmd(cmd), .ba(ba), .addr(addr),
    .bank_open(bank_open), .bank_row(bank_row), .burst_len(burst_len),
    .burst_type(burst_type), .cas_lat(cas_lat), .op_mode(op_mode),
    .err_flag(err_flag), .err_code(err_code)
  );

  function automatic int beats(input logic [2:0] c);
    return (c == 3'd2) ? 2 : (c == 3'd3) ? 4 : 1;
  endfunction

  function automatic logic [51:0] exp_rows();
    logic [51:0] v;
    for (int b = 0; b < 4; b++) v[b*13 +: 13] = m_row[b];
    return v;
  endfunction

  function automatic logic [3:0] exp_open();
    logic [3:0] v;
    for (int b = 0; b < 4; b++) v[b] = m_open[b];
    return v;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmp_all();
    chk("R2 R4 bank_open", 64'(bank_open), 64'(exp_open()));
    chk("R2 bank_row", 64'(bank_row), 64'(exp_rows()));
    chk("R5 mode fields", {51'd0, burst_len, burst_type, cas_lat, op_mode},
        {51'd0, m_bl, m_bt, m_cl, m_op});
    chk("R10 error outputs", {60'd0, err_flag, err_code}, {60'd0, m_err, m_code});
  endtask

  task automatic model_reset();
    for (int b = 0; b < 4; b++) begin m_open[b] = 1'b0; m_row[b] = '0; end
    m_bl = 3'd1; m_bt = 1'b0; m_cl = 3'd2; m_op = '0;
    m_err = 1'b0; m_code = '0; m_burst = 0; m_dll = 0;
  endtask

  // predicts the state after the edge that samples (k, c, b, a)
  task automatic model_step(input logic k, input logic [2:0] c, input logic [1:0] b,
                            input logic [12:0] a);
    int  e = 0;
    bit  start = 0, dload = 0;
    bit  anyo = m_open[0] | m_open[1] | m_open[2] | m_open[3];
    if (k) begin
      case (c)
        3'd1: if (m_open[b]) e = 1; else begin m_open[b] = 1'b1; m_row[b] = a; end
        3'd2, 3'd3: begin
          if (!m_open[b]) e = 2;
          else begin
            if (c == 3'd2 && m_dll != 0) e = 5;
            start = 1;
          end
        end
        3'd4: m_open[b] = 1'b0;
        3'd5: for (int i = 0; i < 4; i++) m_open[i] = 1'b0;
        3'd7: begin
          if (anyo || m_burst != 0) e = 3;
          else if (b == 2'd0) begin
            if (!(a[2:0] inside {3'd1, 3'd2, 3'd3})) e = 4;
            else begin
              m_bl = a[2:0]; m_bt = a[3]; m_cl = a[6:4];
              m_op = a[12:7]; m_op[1] = 1'b0;
              dload = a[8];
            end
          end
        end
        default: ;
      endcase
    end
    m_burst = start ? beats(m_bl) : (m_burst > 0 ? m_burst - 1 : 0);
    m_dll   = dload ? GAP - 1 : (m_dll > 0 ? m_dll - 1 : 0);
    if (!m_err && e != 0) begin m_err = 1'b1; m_code = 3'(e); end
  endtask

  // called at a negative edge: drive, let one rising edge pass, compare
  task automatic step(input logic k, input logic [2:0] c, input logic [1:0] b,
                      input logic [12:0] a);
    cke = k; cmd = c; ba = b; addr = a;
    model_step(k, c, b, a);
    @(negedge clk);
    cmp_all();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cke = 1'b1; cmd = 3'd0; ba = '0; addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
  endtask

  task automatic dll_case(input int n, input logic exp_err);
    do_reset();
    step(1, 3'd7, 2'd0, 13'h0112);        // DLL reset, burst code 2
    step(1, 3'd1, 2'd0, 13'h0055);        // n = 1
    repeat (n - 2) step(1, 3'd0, 2'd0, 13'h0);
    step(1, 3'd2, 2'd0, 13'h0004);        // READ at edge n
    chk("R9 DLL gap error flag", 64'(err_flag), 64'(exp_err));
    if (exp_err) chk("R9 DLL gap code", 64'(err_code), 64'd5);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    chk("R5 reset mode values", {57'd0, burst_len, burst_type, cas_lat}, {57'd0, 3'd1, 1'b0, 3'd2});
    chk("R10 reset error clear", {60'd0, err_flag, err_code}, 64'd0);

    // R2: open, row record, double open
    step(1, 3'd1, 2'd2, 13'h1ABC);
    chk("R2 row stored", 64'(bank_row[38:26]), 64'h1ABC);
    step(1, 3'd1, 2'd2, 13'h0123);
    chk("R2 double ACTIVE code", 64'(err_code), 64'd1);
    chk("R2 row kept", 64'(bank_row[38:26]), 64'h1ABC);

    // R3
    do_reset();
    step(1, 3'd3, 2'd0, 13'h0008);
    chk("R3 WRITE idle code", 64'(err_code), 64'd2);

    // R1 and R4
    do_reset();
    step(0, 3'd1, 2'd1, 13'h0777);
    chk("R1 cke low ignored", 64'(bank_open), 64'd0);
    step(1, 3'd1, 2'd0, 13'h0001);
    step(1, 3'd1, 2'd1, 13'h0002);
    step(1, 3'd1, 2'd3, 13'h0003);
    step(1, 3'd4, 2'd1, 13'h0);
    chk("R4 single close", 64'(bank_open), 64'b1001);
    step(0, 3'd5, 2'd0, 13'h0);
    chk("R1 cke low PALL ignored", 64'(bank_open), 64'b1001);
    step(1, 3'd5, 2'd0, 13'h0);
    chk("R4 close all", 64'(bank_open), 64'd0);

    // R5, R7: main load then extended load
    step(1, 3'd7, 2'd0, {6'b101011, 3'b011, 1'b1, 3'd3});
    chk("R5 fields latched", {57'd0, burst_len, burst_type, cas_lat}, {57'd0, 3'd3, 1'b1, 3'd3});
    chk("R7 DLL bit cleared", 64'(op_mode), 64'b101001);
    step(1, 3'd7, 2'd1, 13'h1FFF);
    chk("R5 extended load leaves main", 64'(burst_len), 64'd3);
    chk("R10 still clear", 64'(err_flag), 64'd0);

    // R8: busy by open bank, then by burst in progress
    do_reset();
    step(1, 3'd1, 2'd0, 13'h0010);
    step(1, 3'd7, 2'd0, 13'h0002);
    chk("R8 load with open bank", 64'(err_code), 64'd3);
    chk("R8 load discarded", 64'(burst_len), 64'd1);
    do_reset();
    step(1, 3'd7, 2'd0, 13'h0003);        // burst of 8
    step(1, 3'd1, 2'd1, 13'h0020);
    step(1, 3'd3, 2'd1, 13'h0000);
    step(1, 3'd4, 2'd1, 13'h0);
    step(1, 3'd7, 2'd0, 13'h0001);
    chk("R8 load during burst", 64'(err_code), 64'd3);
    do_reset();                           // burst of 2 drains in one edge
    step(1, 3'd1, 2'd1, 13'h0020);
    step(1, 3'd3, 2'd1, 13'h0000);
    step(1, 3'd4, 2'd1, 13'h0);
    step(1, 3'd7, 2'd0, 13'h0002);
    chk("R8 load after burst legal", {60'd0, err_flag, burst_len}, {60'd0, 1'b0, 3'd2});

    // R6
    do_reset();
    step(1, 3'd7, 2'd0, 13'h0025);
    chk("R6 bad burst code", 64'(err_code), 64'd4);
    chk("R6 load discarded", 64'(cas_lat), 64'd2);

    // R9 boundary
    dll_case(199, 1'b1);
    dll_case(200, 1'b0);

    // R10 first wins
    do_reset();
    step(1, 3'd2, 2'd3, 13'h0);
    step(1, 3'd1, 2'd0, 13'h0);
    step(1, 3'd1, 2'd0, 13'h0);
    chk("R10 first code kept", {60'd0, err_flag, err_code}, {60'd0, 1'b1, 3'd2});

    // random episodes
    for (int ep = 0; ep < 8; ep++) begin
      do_reset();
      for (int i = 0; i < 300; i++) begin
        logic [2:0]  c;
        logic [12:0] a;
        logic [1:0]  b;
        logic        k;
        k = ($urandom % 10) != 0;
        c = 3'($urandom % 8);
        b = 2'($urandom % 4);
        a = 13'($urandom);
        if (c == 3'd7 && ($urandom % 4) != 0) begin
          b = 2'd0; a[2:0] = 3'(1 + $urandom % 3);
        end
        if (c == 3'd7 && ($urandom % 2) == 0) a[8] = 1'b0;
        step(k, c, b, a);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule